// File: doc/BRIEF.md
# Sixteen-Kilobyte Region RAM Mapper

This block turns every CPU memory access into a physical RAM bank number. The two top address bits split the 64KB CPU space into four 16KB regions. The output is a 4-bit bank number and a bit that picks one of two 256KB halves. ROM is never remapped here. The block only decides which RAM bank a region shows.

A mode input selects one of two configurations. In compatible mode the CPU writes one configuration byte, and that byte picks a preset layout of the kind used by the common expansion-RAM scheme. The same write also copies the preset layout into the four region registers, so the two views agree. In mapper mode each region has its own 8-bit register. The CPU writes that register through its own I/O port and can read it back on the same port.

The CPU supplies the upper address byte, which serves both as the memory address (bits 7:6) and as the I/O port selector. It also supplies the I/O write and read strobes, the write data and the mode bit. Register writes take effect at the clock edge. Translation and read-back are combinational from the current register state.

Top module: `ram_mapper_16k`

## Requirements
- R1: While reset is held, and for the first cycle after it is released, region register n holds the value n (bank n, half bit 0, spare bits 0). The configuration byte is zero, so each mode maps region n to bank n in half 0.
- R2: For a memory access, the region is cpu_addr_hi[7:6]. ram_bank and ram_half always show the entry of that region.
- R3: In mapper mode (map_mode=1), an io_wr strobe with cpu_addr_hi equal to 0x7C+n stores io_wdata in region register n. The new value applies from the next clock edge. Bits 3:0 are the bank and bit 4 is the half select.
- R4: An io_rd strobe with cpu_addr_hi in 0x7C..0x7F puts region register cpu_addr_hi[1:0] on io_rdata in the same cycle. A read in the same cycle as a write returns the old value. With no such read, io_rdata is 0x00.
- R5: In compatible mode (map_mode=0), a write to 0x7F with io_wdata[7:6]=2'b11 loads the layout number from io_wdata[2:0] and the page from io_wdata[4:3].
  - The layouts give blocks per region 0..3 as follows: 0:(0,1,2,3), 1:(0,1,2,7), 2:(4,5,6,7), 3:(0,3,2,7). Layouts 4..7 give (0,L,2,3), where L is the layout number.
  - Blocks 0..3 map to banks 0..3.
  - Block k>=4 maps to bank 4*((page+1) mod 4)+(k-4).
- R6: In compatible mode, ram_half is always 0.
- R7: A valid compatible-mode write to 0x7F also writes all four region registers with their layout banks, with the half bit and spare bits at 0. The result can be read back in either mode.
- R8: In compatible mode, writes to 0x7C..0x7E are ignored. So are writes to 0x7F whose io_wdata[7:6] is not 2'b11. Neither the region registers nor the translation change.
- R9: The mode bit selects the source of the translation. Mapper mode uses the region registers. Compatible mode uses the stored layout and page, even after mapper-mode writes have changed the registers.
- R10: In mapper mode, bits 7:5 of a region register are stored and read back but do not affect ram_bank or ram_half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_hi | input | 8 | CPU address bits 15:8 (region and I/O port selector) |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| map_mode | input | 1 | 0 = compatible layouts, 1 = per-region mapper |
| ram_bank | output | 4 | Physical 16KB bank within the selected half |
| ram_half | output | 1 | Selects the upper 256KB half |
| io_rdata | output | 8 | Read-back of the addressed region register, else 0 |

## Verification
A register write, a read-back and a memory translation can all fall in the same cycle on one region. Ports 0x7C..0x7F lie in region 1, so one address drives all three at once. The bench raises io_wr and io_rd together on port 0x7D. In that cycle it expects both io_rdata and ram_bank to show the old contents of region 1. After the edge it expects both to show the new value. A second pairing, a mode change against an earlier mapper write, is judged by switching map_mode and checking that the translation source changes while the read-back register stays as it was.

// File: rtl/ram_mapper_pkg.sv
package ram_mapper_pkg;

    localparam int DATA_W     = 8;
    localparam int BANK_W     = 4;
    localparam int REGION_CNT = 4;
    localparam int IDX_W      = $clog2(REGION_CNT);
    localparam int SPARE_W    = DATA_W - BANK_W - 1;
    localparam int LAYOUT_W   = 3;
    localparam int PAGE_W     = 2;

    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_MAPPER = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               half;
        logic [BANK_W-1:0]  bank;
    } map_entry_t;

    // Block number (0..7) that a preset layout places in a region.
    function automatic logic [2:0] layout_block(input logic [LAYOUT_W-1:0] lay,
                                                input logic [IDX_W-1:0]    region);
        logic [2:0] blk;
        blk = {1'b0, region};
        unique case (lay)
            3'd0: blk = {1'b0, region};
            3'd1: blk = (region == 2'd3) ? 3'd7 : {1'b0, region};
            3'd2: blk = {1'b1, region};
            3'd3: begin
                if (region == 2'd1)      blk = 3'd3;
                else if (region == 2'd3) blk = 3'd7;
                else                     blk = {1'b0, region};
            end
            default: blk = (region == 2'd1) ? lay : {1'b0, region};
        endcase
        return blk;
    endfunction

    // Physical bank for a preset layout; expansion blocks move with the page.
    function automatic logic [BANK_W-1:0] compat_bank(input logic [LAYOUT_W-1:0] lay,
                                                      input logic [PAGE_W-1:0]   page,
                                                      input logic [IDX_W-1:0]    region);
        logic [2:0]        blk;
        logic [PAGE_W-1:0] grp;
        blk = layout_block(lay, region);
        grp = page + 2'd1;
        if (blk[2]) return {grp, blk[1:0]};
        else        return {2'b00, blk[1:0]};
    endfunction

endpackage

// File: rtl/ram_mapper_decode.sv
module ram_mapper_decode
    import ram_mapper_pkg::*;
#(
    parameter int          HI_W      = 8,
    parameter logic [5:0]  PORT_BASE = 6'b011111
) (
    input  logic [HI_W-1:0]  addr_hi,
    input  logic             io_wr,
    input  logic [1:0]       wdata_tag,
    input  logic             mode,
    output logic             port_hit,
    output logic [IDX_W-1:0] port_idx,
    output logic             map_wr,
    output logic             cfg_wr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGION_CNT - 1);

    map_mode_e cur_mode;

    always_comb begin
        cur_mode = map_mode_e'(mode);
        port_hit = (addr_hi[HI_W-1:IDX_W] == PORT_BASE);
        port_idx = addr_hi[IDX_W-1:0];
        map_wr   = 1'b0;
        cfg_wr   = 1'b0;
        unique case (cur_mode)
            MODE_MAPPER: map_wr = io_wr && port_hit;
            MODE_COMPAT: cfg_wr = io_wr && port_hit && (port_idx == LAST_IDX)
                                  && (wdata_tag == 2'b11);
        endcase
    end

endmodule

// File: rtl/ram_mapper_regs.sv
module ram_mapper_regs
    import ram_mapper_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              map_wr,
    input  logic                              cfg_wr,
    input  logic [IDX_W-1:0]                  port_idx,
    input  logic [DATA_W-1:0]                 wdata,
    output map_entry_t [REGION_CNT-1:0]       regs,
    output logic [LAYOUT_W-1:0]               lay_q,
    output logic [PAGE_W-1:0]                 page_q
);

    map_entry_t nxt   [REGION_CNT];
    map_entry_t ident [REGION_CNT];

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_region
        always_comb begin
            ident[g] = '0;
            ident[g].bank = BANK_W'(g);
            nxt[g] = regs[g];
            if (map_wr && (port_idx == IDX_W'(g))) begin
                nxt[g] = map_entry_t'(wdata);
            end else if (cfg_wr) begin
                nxt[g] = '0;
                nxt[g].bank = compat_bank(wdata[2:0], wdata[4:3], IDX_W'(g));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REGION_CNT; i++) regs[i] <= ident[i];
            lay_q  <= '0;
            page_q <= '0;
        end else begin
            for (int i = 0; i < REGION_CNT; i++) regs[i] <= nxt[i];
            if (cfg_wr) begin
                lay_q  <= wdata[2:0];
                page_q <= wdata[4:3];
            end
        end
    end

endmodule

// File: rtl/ram_mapper_xlat.sv
module ram_mapper_xlat
    import ram_mapper_pkg::*;
(
    input  logic [IDX_W-1:0]            region,
    input  logic                        mode,
    input  map_entry_t [REGION_CNT-1:0] regs,
    input  logic [LAYOUT_W-1:0]         lay_q,
    input  logic [PAGE_W-1:0]           page_q,
    input  logic                        rd_en,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [BANK_W-1:0]           ram_bank,
    output logic                        ram_half,
    output logic [DATA_W-1:0]           rd_data
);

    map_mode_e cur_mode;

    always_comb begin
        cur_mode = map_mode_e'(mode);
        ram_bank = '0;
        ram_half = 1'b0;
        unique case (cur_mode)
            MODE_MAPPER: begin
                ram_bank = regs[region].bank;
                ram_half = regs[region].half;
            end
            MODE_COMPAT: begin
                ram_bank = compat_bank(lay_q, page_q, region);
                ram_half = 1'b0;
            end
        endcase
        rd_data = rd_en ? DATA_W'(regs[rd_idx]) : '0;
    end

endmodule

// File: rtl/ram_mapper_16k.sv
module ram_mapper_16k
    import ram_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cpu_addr_hi,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              map_mode,
    output logic [BANK_W-1:0] ram_bank,
    output logic              ram_half,
    output logic [DATA_W-1:0] io_rdata
);

    logic                        port_hit;
    logic [IDX_W-1:0]            port_idx;
    logic                        map_wr;
    logic                        cfg_wr;
    map_entry_t [REGION_CNT-1:0] region_regs;
    logic [LAYOUT_W-1:0]         lay_q;
    logic [PAGE_W-1:0]           page_q;

    ram_mapper_decode u_decode (
        .addr_hi   (cpu_addr_hi),
        .io_wr     (io_wr),
        .wdata_tag (io_wdata[7:6]),
        .mode      (map_mode),
        .port_hit  (port_hit),
        .port_idx  (port_idx),
        .map_wr    (map_wr),
        .cfg_wr    (cfg_wr)
    );

    ram_mapper_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_wr   (map_wr),
        .cfg_wr   (cfg_wr),
        .port_idx (port_idx),
        .wdata    (io_wdata),
        .regs     (region_regs),
        .lay_q    (lay_q),
        .page_q   (page_q)
    );

    ram_mapper_xlat u_xlat (
        .region   (cpu_addr_hi[7:6]),
        .mode     (map_mode),
        .regs     (region_regs),
        .lay_q    (lay_q),
        .page_q   (page_q),
        .rd_en    (io_rd && port_hit),
        .rd_idx   (port_idx),
        .ram_bank (ram_bank),
        .ram_half (ram_half),
        .rd_data  (io_rdata)
    );

endmodule

// File: rtl/ram_mapper_16k_chk.sv
module ram_mapper_16k_chk
    import ram_mapper_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  cpu_addr_hi,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [DATA_W-1:0]           io_wdata,
    input  logic                        map_mode,
    input  logic                        ram_half,
    input  logic [DATA_W-1:0]           io_rdata,
    input  map_entry_t [REGION_CNT-1:0] regs
);

    logic hit;
    assign hit = (cpu_addr_hi[7:2] == 6'b011111);

    for (genvar g = 0; g < REGION_CNT; g++) begin : g_chk
        assert_reset_ident_R1: assert property (@(posedge clk)
            !rst_n |=> (regs[g].bank == BANK_W'(g) && !regs[g].half && regs[g].spare == '0));

        assert_cfg_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!map_mode && io_wr && cpu_addr_hi == 8'h7F && io_wdata[7:6] == 2'b11)
            |=> (regs[g].bank == compat_bank($past(io_wdata[2:0]), $past(io_wdata[4:3]), IDX_W'(g))
                 && !regs[g].half && regs[g].spare == '0));
    end

    assert_map_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_mode && io_wr && hit) |=> (DATA_W'(regs[$past(cpu_addr_hi[1:0])]) == $past(io_wdata)));

    assert_idle_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && hit) |-> (io_rdata == '0));

    assert_compat_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !map_mode |-> !ram_half);

    assert_compat_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_mode && io_wr && hit && (cpu_addr_hi[1:0] != 2'd3 || io_wdata[7:6] != 2'b11))
        |=> $stable(regs));

endmodule

bind ram_mapper_16k ram_mapper_16k_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr_hi (cpu_addr_hi),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_wdata    (io_wdata),
    .map_mode    (map_mode),
    .ram_half    (ram_half),
    .io_rdata    (io_rdata),
    .regs        (region_regs)
);

// File: tb/ram_mapper_16k_bench.sv
module ram_mapper_16k_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr_hi = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic       map_mode = 1'b0;
    logic [3:0] ram_bank;
    logic       ram_half;
    logic [7:0] io_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_mapper_16k u_ram_mapper_16k (
        .clk (clk), .rst_n (rst_n), .cpu_addr_hi (cpu_addr_hi),
        .io_wr (io_wr), .io_rd (io_rd), .io_wdata (io_wdata),
        .map_mode (map_mode), .ram_bank (ram_bank), .ram_half (ram_half),
        .io_rdata (io_rdata)
    );

    function automatic logic [3:0] model_bank(input int lay, input int page, input int region);
        int blk;
        case (lay)
            0: blk = region;
            1: blk = (region == 3) ? 7 : region;
            2: blk = 4 + region;
            3: blk = (region == 1) ? 3 : ((region == 3) ? 7 : region);
            default: blk = (region == 1) ? lay : region;
        endcase
        if (blk < 4) return 4'(blk);
        return 4'((((page + 1) % 4) * 4) + (blk - 4));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] hi, input logic [7:0] d);
        @(negedge clk);
        cpu_addr_hi = hi; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [7:0] exp, input string req);
        @(negedge clk);
        cpu_addr_hi = 8'h7C + 8'(idx); io_rd = 1'b1;
        #1 chk(req, io_rdata, exp);
        io_rd = 1'b0;
    endtask

    task automatic probe(input int region, input logic [3:0] eb, input logic eh, input string req);
        @(negedge clk);
        cpu_addr_hi = {2'(region), 6'h15};
        #1;
        chk(req, {4'h0, ram_bank}, {4'h0, eb});
        chk(req, {7'h0, ram_half}, {7'h0, eh});
    endtask

    task automatic t_reset;
        for (int r = 0; r < 4; r++) probe(r, 4'(r), 1'b0, "R1 compat reset map");
        map_mode = 1'b1;
        for (int r = 0; r < 4; r++) probe(r, 4'(r), 1'b0, "R1 mapper reset map");
        for (int r = 0; r < 4; r++) rd_chk(r, 8'(r), "R1 reset readback");
        @(negedge clk); cpu_addr_hi = 8'h7D; #1 chk("R4 no strobe rdata", io_rdata, 8'h00);
        io_rd = 1'b1; cpu_addr_hi = 8'h6D; #1 chk("R4 wrong port rdata", io_rdata, 8'h00);
        io_rd = 1'b0;
    endtask

    task automatic t_mapper;
        logic [7:0] vals [4];
        vals[0] = 8'h1F; vals[1] = 8'h05; vals[2] = 8'hE9; vals[3] = 8'h13;
        map_mode = 1'b1;
        for (int r = 0; r < 4; r++) wr(8'h7C + 8'(r), vals[r]);
        for (int r = 0; r < 4; r++) rd_chk(r, vals[r], "R3 R4 mapper readback");
        for (int r = 0; r < 4; r++) probe(r, vals[r][3:0], vals[r][4], "R2 R3 R10 mapper translate");
    endtask

    task automatic t_compat;
        map_mode = 1'b0;
        for (int lay = 0; lay < 8; lay++) begin
            for (int pg = 0; pg < 4; pg++) begin
                wr(8'h7F, {2'b11, 1'b0, 2'(pg), 3'(lay)});
                for (int r = 0; r < 4; r++)
                    probe(r, model_bank(lay, pg, r), 1'b0, "R5 R6 compat layout");
                if (pg == 2) begin
                    for (int r = 0; r < 4; r++)
                        rd_chk(r, {4'h0, model_bank(lay, pg, r)}, "R7 compat fill");
                end
            end
        end
    endtask

    task automatic t_switch_and_ignore;
        map_mode = 1'b0;
        wr(8'h7F, 8'hCA);
        probe(0, 4'd8, 1'b0, "R5 layout 2 page 1");
        map_mode = 1'b1;
        probe(0, 4'd8, 1'b0, "R7 R9 mapper sees filled regs");
        wr(8'h7C, 8'hFA);
        probe(0, 4'hA, 1'b1, "R9 R10 mapper source");
        rd_chk(0, 8'hFA, "R10 spare bits stored");
        map_mode = 1'b0;
        probe(0, 4'd8, 1'b0, "R9 R6 compat source after mapper write");
        rd_chk(0, 8'hFA, "R9 regs kept on mode change");
        wr(8'h7C, 8'h13);
        rd_chk(0, 8'hFA, "R8 compat write 7C ignored");
        probe(0, 4'd8, 1'b0, "R8 translate after 7C write");
        wr(8'h7F, 8'h42);
        rd_chk(3, 8'h0B, "R8 untagged 7F ignored");
        probe(1, 4'd9, 1'b0, "R8 layout kept");
    endtask

    task automatic t_same_cycle;
        map_mode = 1'b1;
        wr(8'h7D, 8'h06);
        @(negedge clk);
        cpu_addr_hi = 8'h7D; io_wdata = 8'h0C; io_wr = 1'b1; io_rd = 1'b1;
        #1;
        chk("R4 read during write old", io_rdata, 8'h06);
        chk("R3 translate during write old", {4'h0, ram_bank}, 8'h06);
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        chk("R4 read after write new", io_rdata, 8'h0C);
        chk("R2 R3 translate after write new", {4'h0, ram_bank}, 8'h0C);
        io_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mapper();
        t_compat();
        t_switch_and_ignore();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule